// File: doc/BRIEF.md
# TLB Replacement State Unit

This block holds the replacement-control fields of a 32-bit MMU control register. It serves two translation buffers. The first is a four-way instruction TLB. For it the block keeps six pairwise-age bits, refreshes them whenever an entry is used or refilled, and decodes them into the index of the entry to evict next. The second is a 64-entry unified TLB. For it the block keeps a six-bit round-robin counter that steps on every access and wraps at a boundary that software programs.

Software reads the whole register at all times and can overwrite it in one cycle. Bits outside the two replacement fields are plain storage that software owns. The lookup logic hands this block two things: an instruction-TLB hit strobe together with the way that was used, and a unified-TLB access strobe. It reads back the victim way.

Top module: `tlb_repl_unit`

## Requirements
- R1: An active-low asynchronous reset clears the whole register to 0. The victim output then reads way 3 with `victimValid` = 1.
- R2: When `regWrEn` = 1, the register takes all 32 bits of `regWrData` on the next clock edge, and `regRdData` shows them.
- R3: A software write in the same cycle as a hit strobe or an access strobe takes priority. Only the written value is stored.
- R4: A hit on way i updates the age field in bits [31:26]. Each bit holds one pair (a,b): bit 31=(0,1), 30=(0,2), 29=(0,3), 28=(1,2), 27=(1,3), 26=(2,3). A bit value of 1 means way a is older than way b. The hit clears the bits of pairs where i is a and sets the bits of pairs where i is b.
- R5: The victim is decoded in priority order. Way 0 is chosen when bits[31:29]=111. Way 1 is chosen when bit31=0 and bits[28:27]=11. Way 2 is chosen when bit30=0, bit28=0 and bit26=1. Way 3 is chosen when bits 29, 27 and 26 are all 0.
- R6: When none of the four patterns matches, `victimValid` = 0 and `victimIdx` = 0.
- R7: Each access strobe moves the counter in bits [15:10] to its value plus 1.
- R8: If the incremented value equals the boundary in bits [23:18], the counter becomes 0 instead.
- R9: If the incremented value equals 63, the counter becomes 0 instead.
- R10: With no strobe, the register holds its value. Hardware updates never change bits [25:16] or [9:0].
- R11: A hit strobe and an access strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Value to write |
| itlbHitEn | input | 1 | An instruction-TLB way was used or refilled |
| itlbHitIdx | input | 2 | The way that was used |
| utlbAccess | input | 1 | A unified-TLB access occurred |
| regRdData | output | 32 | Current register contents |
| victimIdx | output | 2 | Way to replace on the next refill |
| victimValid | output | 1 | The age bits decode to a victim |

## Verification
The assertions check five properties on every cycle:
- a write is read back one cycle later;
- a way that was just used is never reported as the victim;
- a counter step never leaves the value 63;
- an idle cycle changes nothing;
- bits outside the hardware-owned fields stay put whenever software does not write.

The exact age masks, the victim table, the counter wrap at the boundary and at the ceiling, and simultaneous strobes depend on specific values. Only the bench's vector sequence and its directed cases show those.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  typedef struct packed {
    logic load;
    logic ageUpd;
    logic cntStep;
  } strobe_t;
endpackage

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl
  import tlb_repl_pkg::*;
(
  input  logic    regWrEn,
  input  logic    itlbHitEn,
  input  logic    utlbAccess,
  output strobe_t strobes
);
  always_comb begin
    strobes.load    = regWrEn;
    strobes.ageUpd  = itlbHitEn & ~regWrEn;
    strobes.cntStep = utlbAccess & ~regWrEn;
  end
endmodule

// File: rtl/tlb_repl_dp.sv
module tlb_repl_dp
  import tlb_repl_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 6,
  parameter int CNT_LSB = 10,
  parameter int BND_LSB = 18,
  parameter int AGE_LSB = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       hitIdx,
  output logic [REG_W-1:0] regQ,
  output logic [1:0]       victimIdx,
  output logic             victimValid
);
  localparam int AGE_W = 6;
  localparam int WAYS  = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [AGE_W-1:0] ageQ, ageNext;
  logic [CNT_W-1:0] cntQ, bndQ, cntNext, cntInc;
  logic [REG_W-1:0] regNext;
  logic [WAYS-1:0]  wayMatch;

  assign ageQ = regQ[AGE_LSB +: AGE_W];
  assign cntQ = regQ[CNT_LSB +: CNT_W];
  assign bndQ = regQ[BND_LSB +: CNT_W];

  // age bit k (MSB first) covers pair (pairA(k), pairB(k))
  function automatic int pairA(input int k);
    case (k)
      5, 4, 3: pairA = 0;
      2, 1:    pairA = 1;
      default: pairA = 2;
    endcase
  endfunction

  function automatic int pairB(input int k);
    case (k)
      5:       pairB = 1;
      4, 2:    pairB = 2;
      default: pairB = 3;
    endcase
  endfunction

  generate
    for (genvar k = 0; k < AGE_W; k++) begin : g_ageBit
      always_comb begin
        if (int'(hitIdx) == pairA(k))      ageNext[k] = 1'b0;
        else if (int'(hitIdx) == pairB(k)) ageNext[k] = 1'b1;
        else                               ageNext[k] = ageQ[k];
      end
    end
  endgenerate

  always_comb begin
    cntInc  = cntQ + 1'b1;
    cntNext = (cntInc == bndQ || cntInc == CNT_MAX) ? '0 : cntInc;
  end

  always_comb begin
    regNext = regQ;
    if (strobes.load) begin
      regNext = wrData;
    end else begin
      if (strobes.ageUpd)  regNext[AGE_LSB +: AGE_W] = ageNext;
      if (strobes.cntStep) regNext[CNT_LSB +: CNT_W] = cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  always_comb begin
    wayMatch[0] = (ageQ[5:3] == 3'b111);
    wayMatch[1] = !ageQ[5] && ageQ[2] && ageQ[1];
    wayMatch[2] = !ageQ[4] && !ageQ[2] && ageQ[0];
    wayMatch[3] = !ageQ[3] && !ageQ[1] && !ageQ[0];
    victimValid = |wayMatch;
    victimIdx   = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (wayMatch[w]) victimIdx = 2'(w);
  end
endmodule

// File: rtl/tlb_repl_unit.sv
module tlb_repl_unit
  import tlb_repl_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 6,
  parameter int CNT_LSB = 10,
  parameter int BND_LSB = 18,
  parameter int AGE_LSB = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             itlbHitEn,
  input  logic [1:0]       itlbHitIdx,
  input  logic             utlbAccess,
  output logic [REG_W-1:0] regRdData,
  output logic [1:0]       victimIdx,
  output logic             victimValid
);
  strobe_t strobes;

  tlb_repl_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .itlbHitEn (itlbHitEn),
    .utlbAccess(utlbAccess),
    .strobes   (strobes)
  );

  tlb_repl_dp #(
    .REG_W  (REG_W),
    .CNT_W  (CNT_W),
    .CNT_LSB(CNT_LSB),
    .BND_LSB(BND_LSB),
    .AGE_LSB(AGE_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (regWrData),
    .hitIdx     (itlbHitIdx),
    .regQ       (regRdData),
    .victimIdx  (victimIdx),
    .victimValid(victimValid)
  );
endmodule

// File: rtl/tlb_repl_checker.sv
module tlb_repl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic        itlbHitEn,
  input logic [1:0]  itlbHitIdx,
  input logic        utlbAccess,
  input logic [31:0] regRdData,
  input logic [1:0]  victimIdx,
  input logic        victimValid
);
  p_sw_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData));

  p_hit_not_victim_r4: assert property (@(posedge clk) disable iff (!rstN)
    (itlbHitEn && !regWrEn) |=> !(victimValid && victimIdx == $past(itlbHitIdx)));

  p_cnt_not_max_r9: assert property (@(posedge clk) disable iff (!rstN)
    (utlbAccess && !regWrEn) |=> regRdData[15:10] != 6'd63);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !itlbHitEn && !utlbAccess) |=> $stable(regRdData));

  p_sw_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(regRdData[25:16]) && $stable(regRdData[9:0])));
endmodule

bind tlb_repl_unit tlb_repl_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .itlbHitEn  (itlbHitEn),
  .itlbHitIdx (itlbHitIdx),
  .utlbAccess (utlbAccess),
  .regRdData  (regRdData),
  .victimIdx  (victimIdx),
  .victimValid(victimValid)
);

// File: tb/test_tlb_repl_unit.sv
`timescale 1ns/1ps
module test_tlb_repl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        itlbHitEn = 1'b0;
  logic [1:0]  itlbHitIdx = '0;
  logic        utlbAccess = 1'b0;
  logic [31:0] regRdData;
  logic [1:0]  victimIdx;
  logic        victimValid;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tlb_repl_unit i_tlb_repl_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .itlbHitEn(itlbHitEn), .itlbHitIdx(itlbHitIdx), .utlbAccess(utlbAccess),
    .regRdData(regRdData), .victimIdx(victimIdx), .victimValid(victimValid)
  );

  // {wr, wrData, hit, idx, acc, expReg, expValid, expVictim}
  localparam int NV = 18;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 32'h0,        1'b1, 2'd0, 1'b0, 32'h00000000, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b1, 2'd3, 1'b0, 32'h2C000000, 1'b1, 2'd2},
    {1'b0, 32'h0,        1'b1, 2'd2, 1'b0, 32'h78000000, 1'b1, 2'd1},
    {1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 32'hE0000000, 1'b1, 2'd0},
    {1'b0, 32'h0,        1'b1, 2'd0, 1'b0, 32'h00000000, 1'b1, 2'd3},
    {1'b1, 32'hB0000000, 1'b0, 2'd0, 1'b0, 32'hB0000000, 1'b0, 2'd0},
    {1'b1, 32'h000C0000, 1'b0, 2'd0, 1'b0, 32'h000C0000, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h000C0400, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h000C0800, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h000C0000, 1'b1, 2'd3},
    {1'b1, 32'h0000F400, 1'b0, 2'd0, 1'b0, 32'h0000F400, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h0000F800, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 32'h00000000, 1'b1, 2'd3},
    {1'b1, 32'h00010203, 1'b0, 2'd0, 1'b0, 32'h00010203, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b1, 2'd2, 1'b1, 32'h50010603, 1'b1, 2'd3},
    {1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 32'h50010603, 1'b1, 2'd3},
    {1'b1, 32'hAAAAAAAA, 1'b1, 2'd1, 1'b1, 32'hAAAAAAAA, 1'b0, 2'd0},
    {1'b0, 32'h0,        1'b1, 2'd3, 1'b0, 32'hAEAAAAAA, 1'b1, 2'd2}
  };

  function automatic string tagOf(input int i);
    case (i)
      0, 1, 2, 3, 4: tagOf = "R4/R5";
      5:             tagOf = "R6";
      6, 10, 13:     tagOf = "R2";
      7, 8, 11:      tagOf = "R7";
      9:             tagOf = "R8";
      12:            tagOf = "R9";
      14:            tagOf = "R11";
      15:            tagOf = "R10";
      16:            tagOf = "R3";
      default:       tagOf = "R4/R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [31:0] eReg,
                          input logic eValid, input logic [1:0] eIdx);
    check({tag, " reg"}, regRdData, eReg);
    check({tag, " victim"}, {29'd0, victimValid, victimIdx}, {29'd0, eValid, eIdx});
  endtask

  task automatic apply(input logic wr, input logic [31:0] d, input logic hit,
                       input logic [1:0] idx, input logic acc);
    regWrEn = wr; regWrData = d; itlbHitEn = hit; itlbHitIdx = idx; utlbAccess = acc;
    @(negedge clk);
    regWrEn = 0; itlbHitEn = 0; utlbAccess = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 in reset", 32'h0, 1'b1, 2'd3);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset", 32'h0, 1'b1, 2'd3);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][71], VEC[i][70:39], VEC[i][38], VEC[i][37:36], VEC[i][35]);
      checkAll(tagOf(i), VEC[i][34:3], VEC[i][2], VEC[i][1:0]);
    end

    // R8: boundary 1, counter 0 -> incremented value hits boundary, stays 0
    apply(1'b1, 32'h00040000, 1'b0, 2'd0, 1'b0);
    apply(1'b0, 32'h0, 1'b0, 2'd0, 1'b1);
    checkAll("R8 boundary one", 32'h00040000, 1'b1, 2'd3);

    // R3: write wins over an access strobe alone
    apply(1'b1, 32'h00007C00, 1'b0, 2'd0, 1'b1);
    checkAll("R3 write vs access", 32'h00007C00, 1'b1, 2'd3);

    // R1: reset in mid-run clears everything
    rstN = 1'b0;
    #1;
    checkAll("R1 mid-run", 32'h0, 1'b1, 2'd3);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule